// File: doc/BRIEF.md
# Interleave Skew Calibration Servo

This controller aligns the sampling instants of a converter array that has eight sub-converters working in turn. While a calibration tone with a period of nine sample intervals drives the array input, the merged sample stream enters the block with a lane tag on each sample. The tone period and the lane count share no factor, so a sample from lane k taken nine times k intervals after a lane-0 sample falls at the same tone phase. Lane k is timed correctly when those two samples are equal.

Lane 0 has a fixed delay and is the timing reference. The block trims lanes 1 to 7 one after another. For each iteration it sums sixteen signed pair differences and moves that lane's 6-bit delay-trim code one step against the sign of the sum. A lane locks after four iterations in a row fall within a programmable tolerance. A lane times out if it has not locked after a fixed number of iterations. A start pulse begins a pass. Busy covers the whole pass, and done pulses once at the end.

Top module: `skewCalTop`

## Requirements
- R1: During and after reset, every trim code reads 32, busy and done are low, and both lane masks are zero.
- R2: start while idle raises busy on the next cycle, clears both lane masks and returns every trim code to 32. start while busy has no effect on the masks or on the pass in progress.
- R3: A pair is formed for lane k when a valid sample tagged k arrives exactly 9·k valid samples after a valid sample tagged 0. The pair difference is the lane-k value minus the lane-0 value. An iteration sums 16 pairs. A sample at that position with a different tag is dropped.
- R4: At the end of an iteration, a sum above the tolerance lowers the active lane's trim by one. A sum below minus the tolerance raises it by one. A sum within the tolerance leaves the trim unchanged.
- R5: Trim codes saturate at 0 and 63 and never wrap.
- R6: When 4 consecutive iterations have |sum| ≤ tolerance, the active lane's bit in lockMask (bit k for lane k) sets and stays set for the rest of the pass.
- R7: A lane that has not locked after MAX_ITER iterations (256 by default) sets its timeoutMask bit, keeps its last trim and hands over to the next lane. No lane has both bits set.
- R8: Lanes are calibrated one at a time in the order 1 to 7. Only the active lane's trim ever moves.
- R9: Lane 0's trim code always reads 32.
- R10: After lane 7 finishes, done is high for exactly one cycle, and busy is low in that cycle.
- R11: The tolerance input sets the lock threshold. With a large tolerance every lane locks at mid-scale after 4 iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a calibration pass when idle |
| tolerance | input | 12 | Lock threshold on the magnitude of the iteration sum |
| sampleValid | input | 1 | A merged-stream sample is present |
| sampleLane | input | 3 | Lane tag of the sample (0 to 7) |
| sampleData | input | 8 | Unsigned sample value |
| trimCodes | output | 48 | Trim code of lane k on bits [6k+5:6k] |
| lockMask | output | 8 | Bit k set when lane k locked |
| timeoutMask | output | 8 | Bit k set when lane k timed out |
| busy | output | 1 | Calibration pass in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The checks assume that the stream keeps strict round-robin order across valid gaps and that tolerance is held steady through a pass. They also assume that start is the only event that may return trims to mid-scale. The stimulus advances one global sample index that sets both the lane tag and the tone phase, and it inserts random idle cycles without breaking the order. A bench plant model turns each lane's live trim code into a sample offset. Some lanes get an inverted plant so that their servo runs into saturation and times out, which exercises the end stops and the hand-over to the next lane.

// File: rtl/skewCalPkg.sv
package skewCalPkg;
  localparam int LANES    = 8;
  localparam int DATA_W   = 8;
  localparam int TRIM_W   = 6;
  localparam int LANE_W   = $clog2(LANES);
  localparam int TRIM_MID = 1 << (TRIM_W - 1);
  localparam int TRIM_TOP = (1 << TRIM_W) - 1;

  typedef struct packed {
    logic              refCapture;
    logic              pairAccum;
    logic              accClear;
    logic              trimInc;
    logic              trimDec;
    logic              trimCenter;
    logic [LANE_W-1:0] lane;
  } servoStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEEK_REF,
    ST_SEEK_PAIR,
    ST_EVAL
  } servoState_t;
endpackage

// File: rtl/skewCalDatapath.sv
module skewCalDatapath
  import skewCalPkg::*;
#(
  parameter int TOL_W = 12,
  parameter int PAIRS = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  servoStrobe_t             strobe,
  input  logic [DATA_W-1:0]        sampleData,
  input  logic [TOL_W-1:0]         tolerance,
  output logic [LANES*TRIM_W-1:0]  trimCodes,
  output logic                     inTol,
  output logic                     accPos
);
  localparam int ACC_W = DATA_W + 1 + $clog2(PAIRS);
  localparam int CMP_W = ACC_W + TOL_W;
  localparam logic [TRIM_W-1:0] MID = TRIM_W'(TRIM_MID);
  localparam logic [TRIM_W-1:0] TOP = TRIM_W'(TRIM_TOP);

  logic [DATA_W-1:0]        refQ;
  logic signed [ACC_W-1:0]  accQ;
  logic signed [DATA_W:0]   pairDiff;
  logic signed [ACC_W-1:0]  pairDiffExt;
  logic [ACC_W-1:0]         accMag;

  assign pairDiff    = $signed({1'b0, sampleData}) - $signed({1'b0, refQ});
  assign pairDiffExt = {{(ACC_W-DATA_W-1){pairDiff[DATA_W]}}, pairDiff};
  assign accMag      = accQ[ACC_W-1] ? ACC_W'(-accQ) : ACC_W'(accQ);
  assign inTol       = ({{TOL_W{1'b0}}, accMag} <= {{ACC_W{1'b0}}, tolerance});
  assign accPos      = !accQ[ACC_W-1] && (accQ != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ <= '0;
      accQ <= '0;
    end else begin
      if (strobe.refCapture) refQ <= sampleData;
      if (strobe.accClear)       accQ <= '0;
      else if (strobe.pairAccum) accQ <= accQ + pairDiffExt;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gTrim
    if (g == 0) begin : gRef
      assign trimCodes[TRIM_W-1:0] = MID;
    end else begin : gAdj
      logic [TRIM_W-1:0] trimQ;
      logic              hit;
      assign hit = (strobe.lane == LANE_W'(g));
      always_ff @(posedge clk) begin
        if (!rstN || strobe.trimCenter) begin
          trimQ <= MID;
        end else if (hit && strobe.trimInc && trimQ != TOP) begin
          trimQ <= trimQ + TRIM_W'(1);
        end else if (hit && strobe.trimDec && trimQ != '0) begin
          trimQ <= trimQ - TRIM_W'(1);
        end
      end
      assign trimCodes[g*TRIM_W +: TRIM_W] = trimQ;
    end
  end
endmodule

// File: rtl/skewCalControl.sv
module skewCalControl
  import skewCalPkg::*;
#(
  parameter int PAIRS    = 16,
  parameter int LOCK_RUN = 4,
  parameter int MAX_ITER = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              sampleValid,
  input  logic [LANE_W-1:0] sampleLane,
  input  logic              inTol,
  input  logic              accPos,
  output servoStrobe_t      strobe,
  output logic              busy,
  output logic              done,
  output logic [LANES-1:0]  lockMask,
  output logic [LANES-1:0]  timeoutMask
);
  localparam int TONE_PERIOD = LANES + 1;
  localparam int GAP_W  = $clog2(TONE_PERIOD * LANES);
  localparam int PAIR_W = $clog2(PAIRS);
  localparam int ITER_W = $clog2(MAX_ITER);
  localparam int RUN_W  = $clog2(LOCK_RUN);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(PAIRS - 1);
  localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(MAX_ITER - 1);
  localparam logic [RUN_W-1:0]  LAST_RUN  = RUN_W'(LOCK_RUN - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  servoState_t       stateQ;
  logic [LANE_W-1:0] laneQ;
  logic [GAP_W-1:0]  gapQ;
  logic [GAP_W-1:0]  gapNext;
  logic [GAP_W-1:0]  targetGap;
  logic [PAIR_W-1:0] pairQ;
  logic [ITER_W-1:0] iterQ;
  logic [RUN_W-1:0]  runQ;
  logic              doneQ;
  logic              pairHere;
  logic              laneLocks;
  logic              laneExpires;

  assign gapNext     = gapQ + GAP_W'(1);
  assign targetGap   = GAP_W'(TONE_PERIOD * int'(laneQ));
  assign pairHere    = sampleValid && (gapNext == targetGap);
  assign laneLocks   = inTol && (runQ == LAST_RUN);
  assign laneExpires = !laneLocks && (iterQ == LAST_ITER);

  always_comb begin
    strobe      = '0;
    strobe.lane = laneQ;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.trimCenter = 1'b1;
          strobe.accClear   = 1'b1;
        end
      end
      ST_SEEK_REF: begin
        if (sampleValid && sampleLane == '0) strobe.refCapture = 1'b1;
      end
      ST_SEEK_PAIR: begin
        if (pairHere && sampleLane == laneQ) strobe.pairAccum = 1'b1;
      end
      ST_EVAL: begin
        strobe.accClear = 1'b1;
        if (!inTol) begin
          strobe.trimDec = accPos;
          strobe.trimInc = !accPos;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      laneQ       <= LANE_W'(1);
      gapQ        <= '0;
      pairQ       <= '0;
      iterQ       <= '0;
      runQ        <= '0;
      doneQ       <= 1'b0;
      lockMask    <= '0;
      timeoutMask <= '0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            stateQ      <= ST_SEEK_REF;
            laneQ       <= LANE_W'(1);
            pairQ       <= '0;
            iterQ       <= '0;
            runQ        <= '0;
            lockMask    <= '0;
            timeoutMask <= '0;
          end
        end
        ST_SEEK_REF: begin
          if (sampleValid && sampleLane == '0) begin
            gapQ   <= '0;
            stateQ <= ST_SEEK_PAIR;
          end
        end
        ST_SEEK_PAIR: begin
          if (pairHere) begin
            stateQ <= ST_SEEK_REF;
            if (sampleLane == laneQ) begin
              if (pairQ == LAST_PAIR) begin
                pairQ  <= '0;
                stateQ <= ST_EVAL;
              end else begin
                pairQ <= pairQ + PAIR_W'(1);
              end
            end
          end else if (sampleValid) begin
            gapQ <= gapNext;
          end
        end
        ST_EVAL: begin
          if (laneLocks || laneExpires) begin
            if (laneLocks) lockMask[laneQ]    <= 1'b1;
            else           timeoutMask[laneQ] <= 1'b1;
            iterQ <= '0;
            runQ  <= '0;
            if (laneQ == LAST_LANE) begin
              stateQ <= ST_IDLE;
              doneQ  <= 1'b1;
            end else begin
              laneQ  <= laneQ + LANE_W'(1);
              stateQ <= ST_SEEK_REF;
            end
          end else begin
            iterQ  <= iterQ + ITER_W'(1);
            runQ   <= inTol ? runQ + RUN_W'(1) : '0;
            stateQ <= ST_SEEK_REF;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;
endmodule

// File: rtl/skewCalTop.sv
module skewCalTop
  import skewCalPkg::*;
#(
  parameter int TOL_W    = 12,
  parameter int PAIRS    = 16,
  parameter int LOCK_RUN = 4,
  parameter int MAX_ITER = 256
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [TOL_W-1:0]        tolerance,
  input  logic                    sampleValid,
  input  logic [LANE_W-1:0]       sampleLane,
  input  logic [DATA_W-1:0]       sampleData,
  output logic [LANES*TRIM_W-1:0] trimCodes,
  output logic [LANES-1:0]        lockMask,
  output logic [LANES-1:0]        timeoutMask,
  output logic                    busy,
  output logic                    done
);
  servoStrobe_t strobe;
  logic         inTol;
  logic         accPos;

  skewCalControl #(
    .PAIRS(PAIRS), .LOCK_RUN(LOCK_RUN), .MAX_ITER(MAX_ITER)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .sampleValid(sampleValid), .sampleLane(sampleLane),
    .inTol(inTol), .accPos(accPos), .strobe(strobe),
    .busy(busy), .done(done),
    .lockMask(lockMask), .timeoutMask(timeoutMask)
  );

  skewCalDatapath #(
    .TOL_W(TOL_W), .PAIRS(PAIRS)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleData(sampleData), .tolerance(tolerance),
    .trimCodes(trimCodes), .inTol(inTol), .accPos(accPos)
  );
endmodule

// File: rtl/skewCalChecker.sv
module skewCalChecker
  import skewCalPkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic [LANES*TRIM_W-1:0] trimCodes,
  input logic [LANES-1:0]        lockMask,
  input logic [LANES-1:0]        timeoutMask,
  input logic                    busy,
  input logic                    done
);
  logic [LANES*TRIM_W-1:0] prevTrim;
  logic                    prevRecenter;
  logic [LANES-1:0]        prevLock;
  logic                    prevBusy;
  logic [LANES-1:0]        moved;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevTrim     <= {LANES{TRIM_W'(TRIM_MID)}};
      prevRecenter <= 1'b0;
      prevLock     <= '0;
      prevBusy     <= 1'b0;
    end else begin
      prevTrim     <= trimCodes;
      prevRecenter <= start && !busy;
      prevLock     <= lockMask;
      prevBusy     <= busy;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [TRIM_W-1:0] cur;
    logic [TRIM_W-1:0] old;
    assign cur      = trimCodes[g*TRIM_W +: TRIM_W];
    assign old      = prevTrim[g*TRIM_W +: TRIM_W];
    assign moved[g] = (cur != old);

    // R4 and R5: a trim moves one step at a time and never wraps
    assert_trim_step_R5: assert property (@(posedge clk) disable iff (!rstN)
      (moved[g] && !prevRecenter) |->
        (({1'b0, cur} == {1'b0, old} + 7'd1) || ({1'b0, cur} + 7'd1 == {1'b0, old})));
  end

  assert_single_lane_R8: assert property (@(posedge clk) disable iff (!rstN)
    !prevRecenter |-> ($countones(moved) <= 1));

  assert_lane0_still_R9: assert property (@(posedge clk) disable iff (!rstN)
    !moved[0]);

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && prevBusy) |-> ((lockMask & prevLock) == prevLock));

  assert_mask_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lockMask & timeoutMask) == '0);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind skewCalTop skewCalChecker uChecker (
  .clk(clk), .rstN(rstN), .start(start), .trimCodes(trimCodes),
  .lockMask(lockMask), .timeoutMask(timeoutMask), .busy(busy), .done(done)
);

// File: tb/sim_skewCalTop.sv
module sim_skewCalTop;
  localparam int LN = 8;
  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [11:0]   tolerance = 12'd20;
  logic          sampleValid = 1'b0;
  logic [2:0]    sampleLane = '0;
  logic [7:0]    sampleData = '0;
  logic [LN*TW-1:0] trimCodes;
  logic [LN-1:0] lockMask;
  logic [LN-1:0] timeoutMask;
  logic          busy;
  logic          done;

  int  passCnt = 0;
  int  totalCnt = 0;
  bit  timedOut = 1'b0;
  bit  plantOn = 1'b0;
  bit  monOn = 1'b0;
  int  sampleIdx = 0;
  int  toneBase = 60;
  int  target [LN];
  bit  inverted [LN];

  always #2 clk = ~clk;

  skewCalTop #(.MAX_ITER(36)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .tolerance(tolerance),
    .sampleValid(sampleValid), .sampleLane(sampleLane), .sampleData(sampleData),
    .trimCodes(trimCodes), .lockMask(lockMask), .timeoutMask(timeoutMask),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  function automatic int trimOf(input int lane);
    return int'(trimCodes[lane*TW +: TW]);
  endfunction

  function automatic int plantValue(input int idx);
    int lane = idx % LN;
    int tone = toneBase + (idx % (LN + 1)) * 15;
    int off;
    int v;
    if (lane == 0) return tone;
    off = 2 * (trimOf(lane) - target[lane]);
    if (inverted[lane]) off = -off;
    v = tone + off;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic int absInt(input int x);
    return (x < 0) ? -x : x;
  endfunction

  // Plant: strict round-robin stream with random idle cycles
  initial begin
    forever begin
      @(negedge clk);
      if (plantOn && ($urandom % 20) != 0) begin
        sampleValid = 1'b1;
        sampleLane  = 3'(sampleIdx % LN);
        sampleData  = 8'(plantValue(sampleIdx));
        sampleIdx++;
      end else begin
        sampleValid = 1'b0;
      end
    end
  end

  // Monitor: lane order (R8) and servo direction (R4)
  logic [LN*TW-1:0] monTrim;
  logic [LN-1:0]    monFin;
  logic             monBusy;
  initial begin
    monTrim = '0; monFin = '0; monBusy = 1'b0;
    forever begin
      @(negedge clk);
      if (monOn) begin
        logic [LN-1:0] fin;
        logic [LN-1:0] fresh;
        int            active;
        fin    = lockMask | timeoutMask;
        fresh  = fin & ~monFin;
        active = LN;
        for (int k = LN - 1; k >= 1; k--) if (!monFin[k]) active = k;
        if (fresh != '0)
          chk(fresh == (LN'(1) << active), "R8", "finish order mask", int'(fresh), 1 << active);
        if (busy && monBusy) begin
          for (int k = 0; k < LN; k++) begin
            int oldT = int'(monTrim[k*TW +: TW]);
            int newT = trimOf(k);
            if (newT != oldT) begin
              chk(k == active, "R8", "moving lane", k, active);
              if (inverted[k])
                chk(absInt(newT - target[k]) == absInt(oldT - target[k]) + 1,
                    "R4", "inverted step", newT, oldT);
              else
                chk(absInt(newT - target[k]) == absInt(oldT - target[k]) - 1,
                    "R4", "step toward match", newT, oldT);
            end
          end
        end
      end
      monTrim = trimCodes;
      monFin  = lockMask | timeoutMask;
      monBusy = busy;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    timedOut = 1'b1;
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done && !timedOut) @(negedge clk);
  endtask

  task automatic checkFinal(input logic [LN-1:0] expLock, input logic [LN-1:0] expTo,
                            input int expTrim [LN], input string req);
    chk(busy == 1'b0, "R10", "busy while done", int'(busy), 0);
    chk(lockMask == expLock, "R6", "lockMask", int'(lockMask), int'(expLock));
    chk(timeoutMask == expTo, "R7", "timeoutMask", int'(timeoutMask), int'(expTo));
    chk(trimOf(0) == 32, "R9", "lane0 trim", trimOf(0), 32);
    for (int k = 1; k < LN; k++)
      chk(trimOf(k) == expTrim[k], req, $sformatf("lane%0d trim", k), trimOf(k), expTrim[k]);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done width", int'(done), 0);
  endtask

  initial begin
    int expTrim [LN];
    void'($urandom(32'd4711));
    for (int k = 0; k < LN; k++) begin target[k] = 32; inverted[k] = 1'b0; end

    // R1 reset state
    repeat (4) @(negedge clk);
    for (int k = 0; k < LN; k++) chk(trimOf(k) == 32, "R1", "reset trim", trimOf(k), 32);
    chk(!busy && !done, "R1", "reset busy/done", int'({busy, done}), 0);
    chk(lockMask == '0 && timeoutMask == '0, "R1", "reset masks",
        int'({lockMask, timeoutMask}), 0);
    rstN = 1'b1;

    // Run 1: mixed plants, tight tolerance
    toneBase = 40 + int'($urandom % 41);
    target[1] = 32;
    foreach (target[k]) if (k == 3 || k == 4 || k == 6 || k == 7)
      target[k] = 22 + int'($urandom % 21);
    target[2] = 40; inverted[2] = 1'b1;
    target[5] = 20; inverted[5] = 1'b1;
    tolerance = 12'd20;
    plantOn = 1'b1;
    monOn = 1'b1;
    pulseStart();
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);

    while (!(lockMask[3] | timeoutMask[3]) && !timedOut) @(negedge clk);
    pulseStart();
    chk(busy && lockMask[1] && lockMask[3], "R2", "start ignored while busy",
        int'({busy, lockMask[1], lockMask[3]}), 7);

    waitDone();
    for (int k = 0; k < LN; k++) expTrim[k] = target[k];
    expTrim[2] = 0;
    expTrim[5] = 63;
    checkFinal(8'b1101_1010, 8'b0010_0100, expTrim, "R3");
    chk(trimOf(2) == 0 && trimOf(5) == 63, "R5", "saturation ends",
        trimOf(2) * 100 + trimOf(5), 63);

    // Run 2: wide tolerance locks everything at mid-scale
    tolerance = 12'd4095;
    for (int k = 1; k < LN; k++) begin
      inverted[k] = 1'b0;
      target[k] = (k % 2 == 0) ? 32 + 5 + int'($urandom % 10) : 32 - 5 - int'($urandom % 10);
    end
    pulseStart();
    chk(lockMask == '0 && timeoutMask == '0, "R2", "masks cleared by start",
        int'({lockMask, timeoutMask}), 0);
    chk(trimOf(2) == 32 && trimOf(5) == 32, "R2", "trims recentred",
        trimOf(2) * 100 + trimOf(5), 3232);
    waitDone();
    for (int k = 0; k < LN; k++) expTrim[k] = 32;
    checkFinal(8'b1111_1110, 8'b0000_0000, expTrim, "R11");

    plantOn = 1'b0;
    monOn = 1'b0;
    if (timedOut) chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule